// File: doc/BRIEF.md
# SPI Flash Write-Enable Control

This block is the device-side command front end of a serial flash that decides whether writes are allowed. It watches the serial clock, chip select and data-in lines, all already brought into the system clock domain. It accepts SPI clock mode 0 or mode 3 and collects command bytes most significant bit first. A command takes effect only when chip select returns high. The block keeps three pieces of state:

- the write-enable latch;
- the auto-address-increment flag;
- a one-shot arming flag that lets a status-register write through.

The program and erase engine sits beside this block. It asks for permission through `prog_req_i`, receives `prog_grant_o`, and reports its own activity on `busy_i`, which this block never alters. A status-register write that is allowed shows up as a one-cycle strobe with its data byte, for the register bank to capture. The serial output driver is held disabled for every command handled here.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After reset, the write-enable latch, the auto-address-increment flag and the arming flag are 0, no strobe is raised, and `status_o` shows bit 0 = busy, bit 1 = write-enable latch, bit 6 = auto-address-increment, with all other bits 0.
- R2: Data-in bits are taken on rising serial clock edges while chip select is low, most significant bit first, with the clock idling either low (mode 0) or high (mode 3). Byte 0x60, which is 0x06 with its bits reversed, does not act as a write-enable.
- R3: A complete opcode 0x06 sets the write-enable latch and arms a status write, on the clock edge at which the chip-select rise is seen.
- R4: A complete opcode 0x04 clears the write-enable latch, the auto-address-increment flag and the arming flag. `status_o` bit 0 keeps following `busy_i`.
- R5: A complete opcode 0x50 arms a status write and leaves the write-enable latch unchanged.
- R6: Opcode 0x01 followed by a full data byte, while the block is armed, raises `wsr_stb_o` for exactly one cycle with that byte on `wsr_data_o`, and clears both the write-enable latch and the arming flag. When the block is not armed, the same command raises no strobe.
- R7: Any other complete command, including opcode 0x01 with fewer than 16 bits, clears the arming flag and leaves the write-enable latch unchanged.
- R8: A chip-select rise after fewer than 8 bits changes no state.
- R9: `prog_grant_o` equals `prog_req_i` while the write-enable latch is 1 and `busy_i` is 0, and is 0 otherwise. `aai_start_i` sets the auto-address-increment flag only under the same condition.
- R10: `so_oe_o` stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, synchronized |
| cs_n_i | input | 1 | Chip select, active low, synchronized |
| si_i | input | 1 | Serial data in, synchronized |
| busy_i | input | 1 | Program/erase engine busy |
| prog_req_i | input | 1 | Program/erase permission request |
| aai_start_i | input | 1 | Auto-address-increment sequence start |
| so_oe_o | output | 1 | Serial output enable (always 0) |
| prog_grant_o | output | 1 | Program/erase request granted |
| write_ok_o | output | 1 | Latch set and engine idle |
| wel_o | output | 1 | Write-enable latch |
| aai_o | output | 1 | Auto-address-increment flag |
| armed_o | output | 1 | Status write armed |
| status_o | output | 8 | Status byte |
| wsr_stb_o | output | 1 | Status write strobe |
| wsr_data_o | output | 8 | Status write data |

## Verification
If the latch or arming flag holds a wrong value, the fault shows up one clock after the chip-select rise. It appears on `wel_o` and `armed_o`, and at the same moment on `write_ok_o` and `prog_grant_o`. If a bit is shifted in the wrong order, or a partial byte is counted as a command, the wrong command is decoded. That error surfaces on the same edge, or on the next status-write attempt, as a missing or extra strobe. A behavioural model in the bench tracks every output on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;
  localparam int OPW  = 8;
  localparam int CNTW = $clog2(2 * OPW + 1);

  localparam logic [OPW-1:0] OP_WREN = 8'h06;
  localparam logic [OPW-1:0] OP_WRDI = 8'h04;
  localparam logic [OPW-1:0] OP_EWSR = 8'h50;
  localparam logic [OPW-1:0] OP_WRSR = 8'h01;

  typedef struct packed {
    logic wren;
    logic wrdi;
    logic ewsr;
    logic wsr_ok;
    logic other;
  } cmd_evt_t;

  function automatic cmd_evt_t decode_cmd(input logic fire,
                                          input logic [OPW-1:0] op,
                                          input logic [CNTW-1:0] nbits,
                                          input logic armed);
    cmd_evt_t e;
    e = '0;
    if (fire && nbits >= CNTW'(OPW)) begin
      unique case (op)
        OP_WREN: e.wren = 1'b1;
        OP_WRDI: e.wrdi = 1'b1;
        OP_EWSR: e.ewsr = 1'b1;
        OP_WRSR: begin
          if (armed && nbits == CNTW'(2 * OPW)) e.wsr_ok = 1'b1;
          else                                   e.other  = 1'b1;
        end
        default: e.other = 1'b1;
      endcase
    end
    return e;
  endfunction

  function automatic logic [7:0] pack_status(input logic busy,
                                             input logic wel,
                                             input logic aai);
    logic [7:0] s;
    s    = '0;
    s[0] = busy;
    s[1] = wel;
    s[6] = aai;
    return s;
  endfunction
endpackage

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_wel_pkg::*;
#(
  parameter int W  = OPW,
  parameter int CW = $clog2(2 * W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_n_i,
  input  logic          si_i,
  output logic [W-1:0]  op_o,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] nbits_o,
  output logic          cs_rise_o
);
  localparam logic [CW-1:0] FULL   = CW'(2 * W);
  localparam logic [CW-1:0] OPLAST = CW'(W - 1);
  localparam logic [CW-1:0] DLAST  = CW'(2 * W - 1);

  logic          sck_q, cs_q;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic          sck_rise;
  logic [W-1:0]  sh_next;

  assign sck_rise  = sck_i & ~sck_q & ~cs_n_i;
  assign cs_rise_o = ~cs_q & cs_n_i;
  assign sh_next   = {sh_q[W-2:0], si_i};
  assign nbits_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
      op_o   <= '0;
      data_o <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
      if (cs_n_i) begin
        cnt_q <= '0;
      end else if (sck_rise && cnt_q != FULL) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == OPLAST) op_o   <= sh_next;
        if (cnt_q == DLAST)  data_o <= sh_next;
      end
    end
  end

  assert_cnt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_wel_pkg::*;
(
  input  logic            fire_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [CNTW-1:0] nbits_i,
  input  logic            armed_i,
  output cmd_evt_t        evt_o
);
  always_comb evt_o = decode_cmd(fire_i, op_i, nbits_i, armed_i);
endmodule

// File: rtl/spi_wel_state.sv
module spi_wel_state
  import spi_wel_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_rise_i,
  input  cmd_evt_t     evt_i,
  input  logic [W-1:0] data_i,
  input  logic         busy_i,
  input  logic         aai_start_i,
  output logic         wel_o,
  output logic         aai_o,
  output logic         armed_o,
  output logic         write_ok_o,
  output logic         wsr_stb_o,
  output logic [W-1:0] wsr_data_o
);
  logic wel_q, aai_q, armed_q, stb_q;
  logic [W-1:0] wdat_q;

  assign write_ok_o = wel_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q   <= 1'b0;
      aai_q   <= 1'b0;
      armed_q <= 1'b0;
      stb_q   <= 1'b0;
      wdat_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (aai_start_i && write_ok_o) aai_q <= 1'b1;
      if (evt_i.wren) begin
        wel_q   <= 1'b1;
        armed_q <= 1'b1;
      end
      if (evt_i.wrdi) begin
        wel_q   <= 1'b0;
        aai_q   <= 1'b0;
        armed_q <= 1'b0;
      end
      if (evt_i.ewsr) armed_q <= 1'b1;
      if (evt_i.wsr_ok) begin
        wel_q   <= 1'b0;
        armed_q <= 1'b0;
        stb_q   <= 1'b1;
        wdat_q  <= data_i;
      end
      if (evt_i.other) armed_q <= 1'b0;
    end
  end

  assign wel_o      = wel_q;
  assign aai_o      = aai_q;
  assign armed_o    = armed_q;
  assign wsr_stb_o  = stb_q;
  assign wsr_data_o = wdat_q;

  assert_wrdi_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.wrdi |=> (!wel_q && !aai_q && !armed_q));
  assert_wsr_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.wsr_ok |=> (!wel_q && !armed_q && stb_q));
  assert_stb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  assert_arm_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise_i |=> $stable(armed_q) && $stable(wel_q));
  assert_aai_needs_wel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aai_q) |-> $past(wel_q));
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
  import spi_wel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_n_i,
  input  logic       si_i,
  input  logic       busy_i,
  input  logic       prog_req_i,
  input  logic       aai_start_i,
  output logic       so_oe_o,
  output logic       prog_grant_o,
  output logic       write_ok_o,
  output logic       wel_o,
  output logic       aai_o,
  output logic       armed_o,
  output logic [7:0] status_o,
  output logic       wsr_stb_o,
  output logic [7:0] wsr_data_o
);
  logic [OPW-1:0]  op, data;
  logic [CNTW-1:0] nbits;
  logic            cs_rise;
  cmd_evt_t        evt;

  spi_rx_shift #(.W(OPW), .CW(CNTW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_n_i(cs_n_i), .si_i(si_i),
    .op_o(op), .data_o(data), .nbits_o(nbits), .cs_rise_o(cs_rise)
  );

  spi_cmd_decode u_dec (
    .fire_i(cs_rise), .op_i(op), .nbits_i(nbits), .armed_i(armed_o), .evt_o(evt)
  );

  spi_wel_state #(.W(OPW)) u_st (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_rise_i(cs_rise), .evt_i(evt), .data_i(data),
    .busy_i(busy_i), .aai_start_i(aai_start_i), .wel_o(wel_o), .aai_o(aai_o),
    .armed_o(armed_o), .write_ok_o(write_ok_o), .wsr_stb_o(wsr_stb_o),
    .wsr_data_o(wsr_data_o)
  );

  assign so_oe_o      = 1'b0;
  assign prog_grant_o = prog_req_i & write_ok_o;
  assign status_o     = pack_status(busy_i, wel_o, aai_o);

  assert_one_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt.wren, evt.wrdi, evt.ewsr, evt.wsr_ok, evt.other}));
  assert_event_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |-> cs_rise);
endmodule

// File: tb/test_spi_wel_ctrl.sv
module test_spi_wel_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic busy = 1'b0, preq = 1'b0, aai_st = 1'b0;
  logic so_oe, grant, wok, wel, aai, armed, stb;
  logic [7:0] status, wdata;

  int errors = 0, checks = 0;
  int stb_count = 0;
  logic [7:0] stb_last = '0;

  always #10 clk = ~clk;

  spi_wel_ctrl i_spi_wel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .busy_i(busy), .prog_req_i(preq), .aai_start_i(aai_st), .so_oe_o(so_oe),
    .prog_grant_o(grant), .write_ok_o(wok), .wel_o(wel), .aai_o(aai),
    .armed_o(armed), .status_o(status), .wsr_stb_o(stb), .wsr_data_o(wdata)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit   q[$];
  logic m_sck_p, m_cs_p, m_wel, m_aai, m_arm, m_stb;
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_sck_p = 0; m_cs_p = 1; m_wel = 0; m_aai = 0; m_arm = 0; m_stb = 0; m_data = 0;
    end else begin
      logic ok_before, wrdi_now;
      logic [7:0] op, dat;
      ok_before = m_wel && !busy;
      wrdi_now  = 0;
      m_stb     = 0;
      if (!m_cs_p && cs_n && q.size() >= 8) begin
        op = 0; dat = 0;
        for (int i = 0; i < 8; i++) op = {op[6:0], q[i]};
        if (q.size() == 16) for (int i = 8; i < 16; i++) dat = {dat[6:0], q[i]};
        if (op == 8'h06) begin m_wel = 1; m_arm = 1; end
        else if (op == 8'h04) begin m_wel = 0; m_arm = 0; wrdi_now = 1; end
        else if (op == 8'h50) m_arm = 1;
        else if (op == 8'h01 && m_arm && q.size() == 16) begin
          m_wel = 0; m_arm = 0; m_stb = 1; m_data = dat;
        end else m_arm = 0;
      end
      if (wrdi_now) m_aai = 0;
      else if (aai_st && ok_before) m_aai = 1;
      if (cs_n) q.delete();
      else if (sck && !m_sck_p && q.size() < 16) q.push_back(si);
      m_sck_p = sck; m_cs_p = cs_n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R3", "wel", {7'b0, wel}, {7'b0, m_wel});
    chk("R5", "armed", {7'b0, armed}, {7'b0, m_arm});
    chk("R9", "aai", {7'b0, aai}, {7'b0, m_aai});
    chk("R6", "wsr_stb", {7'b0, stb}, {7'b0, m_stb});
    if (m_stb) chk("R6", "wsr_data", wdata, m_data);
    chk("R9", "grant", {7'b0, grant}, {7'b0, preq & m_wel & ~busy});
    chk("R4", "status", status, {1'b0, m_aai, 4'b0, m_wel, busy});
    chk("R10", "so_oe", {7'b0, so_oe}, 8'h00);
    if (stb) begin stb_count++; stb_last = wdata; end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n, input bit mode3);
    @(negedge clk); sck = mode3; clks(1); cs_n = 0; clks(2);
    for (int i = 0; i < n; i++) begin
      sck = 0; si = v[15 - i]; clks(2);
      sck = 1; clks(2);
    end
    if (!mode3) sck = 0;
    clks(2); cs_n = 1; clks(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL all watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clks(3);
    chk("R1", "wel in reset", {7'b0, wel}, 8'h00);
    rst_n = 1; clks(2);
    chk("R1", "status after reset", status, 8'h00);
    chk("R1", "armed after reset", {7'b0, armed}, 8'h00);
    chk("R10", "so_oe after reset", {7'b0, so_oe}, 8'h00);

    send({8'h60, 8'h00}, 8, 0);             // R2: reversed bit order
    chk("R2", "0x60 not wren", {7'b0, wel}, 8'h00);
    send({8'h06, 8'h00}, 8, 0);
    chk("R3", "wren sets wel", {7'b0, wel}, 8'h01);
    chk("R3", "wren arms", {7'b0, armed}, 8'h01);

    send({8'h01, 8'hA5}, 16, 0);
    chk("R6", "strobe count", stb_count[7:0], 8'd1);
    chk("R6", "strobe data", stb_last, 8'hA5);
    chk("R6", "wel cleared", {7'b0, wel}, 8'h00);
    send({8'h01, 8'h3C}, 16, 1);
    chk("R6", "no strobe unarmed", stb_count[7:0], 8'd1);

    send({8'h50, 8'h00}, 8, 1);             // mode 3, R2
    chk("R5", "ewsr arms", {7'b0, armed}, 8'h01);
    chk("R2", "mode3 ewsr wel", {7'b0, wel}, 8'h00);
    send({8'h06, 8'h00}, 5, 0);
    chk("R8", "partial keeps arm", {7'b0, armed}, 8'h01);
    chk("R8", "partial no wel", {7'b0, wel}, 8'h00);
    send({8'h50, 8'h00}, 8, 0);
    send({8'h01, 8'h5A}, 16, 1);
    chk("R5", "ewsr write strobe", stb_last, 8'h5A);
    send({8'h03, 8'h00}, 16, 0);
    chk("R7", "read disarms", {7'b0, armed}, 8'h00);

    send({8'h06, 8'h00}, 8, 1);
    busy = 1; preq = 1; aai_st = 1; clks(2);
    chk("R9", "busy blocks grant", {7'b0, grant}, 8'h00);
    chk("R9", "busy blocks aai", {7'b0, aai}, 8'h00);
    busy = 0; clks(1);
    chk("R9", "grant when wel", {7'b0, grant}, 8'h01);
    clks(1);
    chk("R9", "aai set", {7'b0, aai}, 8'h01);
    aai_st = 0; preq = 0; busy = 1; clks(1);
    chk("R1", "status layout", status, 8'h43);

    send({8'h04, 8'h00}, 8, 0);
    chk("R4", "wrdi status", status, 8'h01);
    busy = 0; clks(1);
    chk("R4", "busy untouched", status, 8'h00);

    send({8'h06, 8'h00}, 8, 0);
    send({8'h01, 8'h77}, 8, 0);
    chk("R7", "short wrsr disarms", {7'b0, armed}, 8'h00);
    chk("R7", "short wrsr keeps wel", {7'b0, wel}, 8'h01);
    chk("R7", "short wrsr no strobe", stb_count[7:0], 8'd2);

    clks(4);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule